// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a small synchronous static memory whose bus never needs an idle cycle between a read and a write. Every control input is sampled on the rising clock edge. A command is a read, a write, a deselect, or a burst continuation. A write presents its address with the command and its data one or two cycles later. Because of that delay, a read can follow a write, and a write can follow a read, in every cycle with no gap. It serves as a behavioural memory model or as an on-chip buffer.

Two static straps set the mode. The first selects flow-through timing (single late write, read data in the cycle after the command edge) or pipelined timing (double late write, read data one cycle later through an output register). The second sets the beat order of a four-beat burst: linear or interleaved. Three chip selects must all be active for a load to be accepted. An asynchronous output enable can blank the data outputs at any moment. A read whose address still has write data in flight returns that data, merged lane by lane with the stored word.

Top module: `zt_sram`

## Requirements
- R1: While `rst_n` is low, and directly after its release, `dq_drive` is 0 and `dq_out` is all zeros, and no command is in flight.
- R2: In flow-through mode (`mode_pipe`=0), a read load sampled at edge k drives `dq_drive`=1 and the addressed word on `dq_out` from just after edge k until edge k+1.
- R3: In pipelined mode (`mode_pipe`=1), a read load sampled at edge k drives `dq_drive`=1 and the addressed word from just after edge k+1 until edge k+2.
- R4: In flow-through mode, the data for a write command sampled at edge k is taken from `wdata` at edge k+1.
- R5: In pipelined mode, the data for a write command sampled at edge k is taken from `wdata` at edge k+2.
- R6: A word holds 2 lanes of 9 bits. Lane i is bits [9i+8:9i] and is written only when `ben[i]`=1. A lane with `ben[i]`=0 keeps its old content.
- R7: A load (`adv`=0) is accepted only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other pattern is a deselect: nothing is written, the next output window has `dq_drive`=0, and any active burst ends.
- R8: A read issued right after writes to the same address returns the newest written lanes, even when those lanes are not yet in the array. Reads and writes may alternate every cycle.
- R9: With `burst_ilv`=0, beat n of a burst (n counted from 0 at the load) uses address bits [1:0] equal to (start + n) mod 4. The upper bits come from the load. The count keeps wrapping past four beats.
- R10: With `burst_ilv`=1, beat n uses address bits [1:0] equal to start XOR (n mod 4).
- R11: `adv`=1 continues the last accepted load with the same read or write type and ignores the chip selects. With no burst active (after reset or a deselect), `adv`=1 is a deselect.
- R12: `oe_n`=1 forces `dq_drive`=0 and `dq_out` to zero at once, and leaves the read pipeline undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pipe | input | 1 | Static strap: 1 pipelined, 0 flow-through |
| burst_ilv | input | 1 | Static strap: 1 interleaved burst order, 0 linear |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 continues the burst, 0 loads a new command |
| wr | input | 1 | 1 write, 0 read (on loads) |
| ben | input | 2 | Per-lane write enables, active high |
| addr | input | 6 | Word address |
| wdata | input | 18 | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | 18 | Read data, zero when not driven |
| dq_drive | output | 1 | High while `dq_out` carries valid read data |

## Verification
The main function is driven with random mixes of loads, burst beats, writes with random lane enables and deselects, in all four strap combinations. Every read is compared against a word model that is updated when the command is issued. This separates correct late-write alignment and bypass from stale-array reads, because any misaligned data edge or missing merge shows up as a wrong word. Directed sequences add cases the random mix does not pin down. Back-to-back write-then-read to one address checks both latencies. The seven rejected chip-select patterns are tried with a write. A burst runs past four beats in each order to check wrapping. An advance is issued with no active burst. Output enable is pulsed between two reads to show blanking without loss.

// File: rtl/zt_pkg.sv
package zt_pkg;
  localparam int BEATS = 4;
  localparam int LO_W  = $clog2(BEATS);

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2
  } cmd_e;

  // Low address bits of a burst beat from its start and beat count.
  function automatic logic [LO_W-1:0] beat_lo(input logic [LO_W-1:0] start,
                                              input logic [LO_W-1:0] cnt,
                                              input logic            ilv);
    return ilv ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/zt_burst_ctl.sv
module zt_burst_ctl
  import zt_pkg::*;
#(
  parameter int AW = 6,
  parameter int NL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ilv,
  input  logic          sel_ok,
  input  logic          adv,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [NL-1:0] ben,
  output cmd_e          cmd_o,
  output logic [AW-1:0] addr_o,
  output logic [NL-1:0] ben_o
);
  logic            act_q,  act_d;
  logic            wr_q,   wr_d;
  logic [AW-1:0]   base_q, base_d;
  logic [LO_W-1:0] cnt_q,  cnt_d;
  cmd_e            cmd_q,  cmd_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [NL-1:0]   ben_q,  ben_d;

  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    cmd_d  = CMD_IDLE;
    addr_d = addr_q;
    ben_d  = ben;
    if (!adv) begin
      if (sel_ok) begin
        act_d  = 1'b1;
        wr_d   = wr;
        base_d = addr;
        cnt_d  = '0;
        cmd_d  = wr ? CMD_WR : CMD_RD;
        addr_d = addr;
      end else begin
        act_d = 1'b0;
      end
    end else if (act_q) begin
      cnt_d  = cnt_q + 1'b1;
      cmd_d  = wr_q ? CMD_WR : CMD_RD;
      addr_d = {base_q[AW-1:LO_W], beat_lo(base_q[LO_W-1:0], cnt_q + 1'b1, ilv)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      cmd_q  <= CMD_IDLE;
      addr_q <= '0;
      ben_q  <= '0;
    end else begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      ben_q  <= ben_d;
    end
  end

  assign cmd_o  = cmd_q;
  assign addr_o = addr_q;
  assign ben_o  = ben_q;

  // R11
  idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !act_q) |=> (cmd_o == CMD_IDLE));

  // R9
  burst_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && act_q && cmd_o != CMD_IDLE) |=> (addr_o[AW-1:LO_W] == $past(addr_o[AW-1:LO_W])));
endmodule

// File: rtl/zt_late_write.sv
module zt_late_write
  import zt_pkg::*;
#(
  parameter int AW = 6,
  parameter int NL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe,
  input  cmd_e          s1_cmd,
  input  logic [AW-1:0] s1_addr,
  input  logic [NL-1:0] s1_ben,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [NL-1:0] wben_o
);
  cmd_e          s2_cmd_q,  s2_cmd_d;
  logic [AW-1:0] s2_addr_q, s2_addr_d;
  logic [NL-1:0] s2_ben_q,  s2_ben_d;

  always_comb begin
    s2_cmd_d  = s1_cmd;
    s2_addr_d = s1_addr;
    s2_ben_d  = s1_ben;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_cmd_q  <= CMD_IDLE;
      s2_addr_q <= '0;
      s2_ben_q  <= '0;
    end else begin
      s2_cmd_q  <= s2_cmd_d;
      s2_addr_q <= s2_addr_d;
      s2_ben_q  <= s2_ben_d;
    end
  end

  // Flow-through commits from stage 1, pipelined from stage 2.
  always_comb begin
    if (pipe) begin
      we_o    = (s2_cmd_q == CMD_WR);
      waddr_o = s2_addr_q;
      wben_o  = s2_ben_q;
    end else begin
      we_o    = (s1_cmd == CMD_WR);
      waddr_o = s1_addr;
      wben_o  = s1_ben;
    end
  end

  // R5
  dbl_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && we_o) |-> ($past(s1_cmd) == CMD_WR));
endmodule

// File: rtl/zt_array.sv
module zt_array #(
  parameter int AW = 6,
  parameter int NL = 2,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [NL-1:0]    wben,
  input  logic [NL*BW-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [NL*BW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic same_word;
  assign same_word = we && (waddr == raddr);

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [BW-1:0] mem_l [DEPTH];
    logic          lane_we;

    assign lane_we = we && wben[g];

    always_ff @(posedge clk) begin
      if (lane_we) mem_l[waddr] <= wdata[g*BW +: BW];
    end

    // Pending lane data overrides the stored lane.
    assign rdata[g*BW +: BW] = (same_word && wben[g]) ? wdata[g*BW +: BW] : mem_l[raddr];
  end
endmodule

// File: rtl/zt_out_stage.sv
module zt_out_stage #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe,
  input  logic          rd_en,
  input  logic [DW-1:0] rd_data,
  input  logic          oe_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_drive
);
  logic          q_vld,  vld_d;
  logic [DW-1:0] q_data, data_d;
  logic          drive_int;
  logic [DW-1:0] data_sel;

  always_comb begin
    vld_d  = rd_en;
    data_d = q_data;
    if (rd_en) data_d = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld  <= 1'b0;
      q_data <= '0;
    end else begin
      q_vld  <= vld_d;
      q_data <= data_d;
    end
  end

  assign drive_int = pipe ? q_vld : rd_en;
  assign data_sel  = pipe ? q_data : rd_data;
  assign dq_drive  = drive_int && !oe_n;
  assign dq_out    = dq_drive ? data_sel : '0;

  // R3
  pipe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && rd_en) |=> (dq_drive || oe_n));

  // R2
  flow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && !rd_en) |-> !dq_drive);
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_pipe,
  input  logic                    burst_ilv,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    adv,
  input  logic                    wr,
  input  logic [LANES-1:0]        ben,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*BYTE_W-1:0] wdata,
  input  logic                    oe_n,
  output logic [LANES*BYTE_W-1:0] dq_out,
  output logic                    dq_drive
);
  localparam int DATA_W = LANES * BYTE_W;

  logic              sel_ok;
  cmd_e              s1_cmd;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_ben;
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [LANES-1:0]  wben;
  logic [DATA_W-1:0] rd_word;
  logic              rd_en;

  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;
  assign rd_en  = (s1_cmd == CMD_RD);

  zt_burst_ctl #(.AW(ADDR_W), .NL(LANES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ilv(burst_ilv), .sel_ok(sel_ok), .adv(adv),
    .wr(wr), .addr(addr), .ben(ben),
    .cmd_o(s1_cmd), .addr_o(s1_addr), .ben_o(s1_ben)
  );

  zt_late_write #(.AW(ADDR_W), .NL(LANES)) u_lw (
    .clk(clk), .rst_n(rst_n), .pipe(mode_pipe),
    .s1_cmd(s1_cmd), .s1_addr(s1_addr), .s1_ben(s1_ben),
    .we_o(we), .waddr_o(waddr), .wben_o(wben)
  );

  zt_array #(.AW(ADDR_W), .NL(LANES), .BW(BYTE_W)) u_arr (
    .clk(clk), .we(we), .waddr(waddr), .wben(wben), .wdata(wdata),
    .raddr(s1_addr), .rdata(rd_word)
  );

  zt_out_stage #(.DW(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .pipe(mode_pipe), .rd_en(rd_en),
    .rd_data(rd_word), .oe_n(oe_n), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  // R7
  desel_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !sel_ok) |=> (s1_cmd == CMD_IDLE));
endmodule

// File: tb/zt_sram_bench.sv
module zt_sram_bench;
  localparam int PERIOD = 10;
  localparam int AW = 6;
  localparam int NL = 2;
  localparam int BW = 9;
  localparam int DW = NL * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_pipe, burst_ilv;
  logic          sel_a_n, sel_b, sel_c_n, adv, wr, oe_n;
  logic [NL-1:0] ben;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] dq_out;
  logic          dq_drive;

  zt_sram #(.ADDR_W(AW), .LANES(NL), .BYTE_W(BW)) u_zt_sram (
    .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .burst_ilv(burst_ilv),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .adv(adv), .wr(wr),
    .ben(ben), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .dq_out(dq_out), .dq_drive(dq_drive)
  );

  always #(PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit probe_oe = 1'b0;

  logic [DW-1:0] refm [DEPTH];
  bit            rv [4];
  logic [DW-1:0] rd [4];
  string         rt [4];
  bit            wv [4];
  logic [DW-1:0] wd [4];

  bit            b_act;
  bit            b_wr;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;

  task automatic check(input string tg, input logic [DW-1:0] got, input logic [DW-1:0] exp,
                       input bit gd, input bit ed);
    n_tests++;
    if (got !== exp || gd !== ed) begin
      n_fail++;
      $display("FAIL %s: drive=%0b data=%h, expected drive=%0b data=%h", tg, gd, got, ed, exp);
    end
  endtask

  task automatic do_reset(input bit pm, input bit il);
    @(negedge clk);
    rst_n = 1'b0; mode_pipe = pm; burst_ilv = il;
    sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1; adv = 1'b0; wr = 1'b0;
    ben = '0; addr = '0; wdata = '0; oe_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet while held in reset
    check("R1", dq_out, '0, dq_drive, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin rv[i] = 1'b0; rt[i] = "R1"; wv[i] = 1'b0; end
    b_act = 1'b0;
    #1;
    check("R1", dq_out, '0, dq_drive, 1'b0);
  endtask

  // One command cycle: check the window that ends at this edge, then drive.
  task automatic issue(input bit adv_i, input logic [2:0] ce, input bit wr_i,
                       input logic [AW-1:0] a, input logic [NL-1:0] b, input string tg);
    bit            sel, eff, ewr;
    logic [AW-1:0] ea;
    logic [1:0]    lo;
    logic [31:0]   r;
    int            s;
    @(negedge clk);
    s = (cyc + 3) % 4;
    if (probe_oe) begin
      oe_n = 1'b1; #1;
      check("R12", dq_out, '0, dq_drive, 1'b0);
      oe_n = 1'b0; #1;
    end
    check(rt[s], dq_out, rv[s] ? rd[s] : '0, dq_drive, rv[s]);
    rv[s] = 1'b0;

    sel = (ce == 3'b010);
    eff = 1'b0; ewr = 1'b0; ea = '0;
    if (!adv_i) begin
      if (sel) begin
        b_act = 1'b1; b_wr = wr_i; b_base = a; b_cnt = 2'd0;
        eff = 1'b1; ewr = wr_i; ea = a;
      end else begin
        b_act = 1'b0;
      end
    end else if (b_act) begin
      b_cnt = b_cnt + 2'd1;
      lo = burst_ilv ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt);
      eff = 1'b1; ewr = b_wr; ea = {b_base[AW-1:2], lo};
    end

    {sel_a_n, sel_b, sel_c_n} = ce;
    adv = adv_i; wr = wr_i; addr = a; ben = b;
    r = $urandom;
    if (wv[cyc % 4]) begin
      wdata = wd[cyc % 4]; wv[cyc % 4] = 1'b0;
    end else begin
      wdata = r[DW-1:0];
    end

    if (eff && ewr) begin
      r = $urandom;
      s = (cyc + (mode_pipe ? 2 : 1)) % 4;
      wv[s] = 1'b1; wd[s] = r[DW-1:0];
      for (int g = 0; g < NL; g++)
        if (b[g]) refm[ea][g*BW +: BW] = r[g*BW +: BW];
    end
    s = (cyc + (mode_pipe ? 1 : 0)) % 4;
    rv[s] = eff && !ewr;
    rd[s] = refm[ea];
    rt[s] = tg;
    cyc++;
  endtask

  task automatic rd_w(input logic [AW-1:0] a, input string tg);
    issue(1'b0, 3'b010, 1'b0, a, '0, tg);
  endtask

  task automatic wr_w(input logic [AW-1:0] a, input logic [NL-1:0] b, input string tg);
    issue(1'b0, 3'b010, 1'b1, a, b, tg);
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) issue(1'b0, 3'b110, 1'b0, '0, '0, "R7");
  endtask

  task automatic burst(input bit w, input logic [AW-1:0] a, input int beats, input string tg);
    issue(1'b0, 3'b010, w, a, '1, tg);
    for (int i = 1; i < beats; i++) issue(1'b1, 3'b010, w, '0, '1, tg);
  endtask

  task automatic rand_phase(input int n);
    logic [31:0] r;
    string       tg;
    for (int i = 0; i < n; i++) begin
      r = $urandom;
      if (r[0])                 tg = burst_ilv ? "R10" : "R9";
      else if (r[3:2] == 2'b00) tg = "R7";
      else                      tg = mode_pipe ? "R3" : "R2";
      issue(r[0], (r[3:2] != 2'b00) ? 3'b010 : r[6:4], r[7], r[13:8], r[15:14], tg);
    end
    nop(3);
  endtask

  task automatic common_directed(input string rtag);
    rd_w(6'd20, rtag);
    probe_oe = 1'b1;
    rd_w(6'd21, "R12");
    probe_oe = 1'b0;
    rd_w(6'd22, rtag);
    nop(2);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < DEPTH; i++) wr_w(i[AW-1:0], '1, "R4");
    nop(2);

    // Flow-through, linear
    wr_w(6'd5, 2'b11, "R4"); rd_w(6'd5, "R4");
    wr_w(6'd6, 2'b10, "R6"); rd_w(6'd6, "R6");
    wr_w(6'd7, 2'b01, "R6"); nop(1); rd_w(6'd7, "R6");
    wr_w(6'd8, 2'b00, "R6"); rd_w(6'd8, "R6");
    for (int p = 0; p < 8; p++)
      if (p != 2) begin
        issue(1'b0, p[2:0], 1'b1, 6'd9, '1, "R7");
        rd_w(6'd9, "R7");
      end
    nop(1);
    issue(1'b1, 3'b010, 1'b1, 6'd10, '1, "R11");
    rd_w(6'd10, "R11");
    issue(1'b0, 3'b010, 1'b0, 6'd12, '0, "R11");
    for (int i = 0; i < 3; i++) issue(1'b1, 3'b111, 1'b0, '0, '0, "R11");
    wr_w(6'd4, 2'b01, "R8"); rd_w(6'd4, "R8"); wr_w(6'd4, 2'b10, "R8"); rd_w(6'd4, "R8");
    burst(1'b0, 6'd14, 6, "R9");
    burst(1'b1, 6'd25, 6, "R9");
    burst(1'b0, 6'd25, 4, "R9");
    common_directed("R2");
    rand_phase(1500);

    // Flow-through, interleaved
    do_reset(1'b0, 1'b1);
    burst(1'b0, 6'd14, 6, "R10");
    burst(1'b1, 6'd27, 4, "R10");
    burst(1'b0, 6'd27, 4, "R10");
    rand_phase(1500);

    // Pipelined, linear
    do_reset(1'b1, 1'b0);
    wr_w(6'd30, '1, "R5"); nop(1); rd_w(6'd30, "R5");
    wr_w(6'd31, 2'b01, "R8"); rd_w(6'd31, "R8");
    wr_w(6'd32, '1, "R8"); wr_w(6'd33, 2'b10, "R8"); rd_w(6'd32, "R8"); rd_w(6'd33, "R8");
    wr_w(6'd34, '1, "R5"); rd_w(6'd35, "R3"); rd_w(6'd34, "R5");
    burst(1'b1, 6'd38, 4, "R9"); burst(1'b0, 6'd38, 6, "R9");
    common_directed("R3");
    rand_phase(1500);

    // Pipelined, interleaved
    do_reset(1'b1, 1'b1);
    burst(1'b1, 6'd41, 4, "R10"); burst(1'b0, 6'd41, 6, "R10");
    rand_phase(1500);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule